// File: doc/BRIEF.md
# Local Bus Interrupt Priority Controller

This block gathers sixteen level-sensitive interrupt lines from local-bus peripherals, qualifies them with a software-controlled enable mask and drives one combined, registered interrupt request toward the processor. Each line is resynchronised into the block's clock domain before it lands in a source register. The source register simply mirrors the line levels: a device keeps its line high until it is serviced.

Software reaches the block through a small 16-bit register port. Reading the vector location gives a code that names the lowest-numbered line which is both asserted and enabled, so a handler can jump straight to the right service routine. The enable mask can be read back and rewritten at any time. Only the low 12 address bits take part in decoding, so the block can sit in any 4 KiB window.

Top module: `lbirq_prio_ctrl`

## Requirements
- R1: Each bit of the source register follows the level of its input line through a two-flop synchroniser; a level applied before clock edge k is in the source register after edge k+2 and reaches `irq_out` at edge k+3.
- R2: `irq_out` is a register that is high exactly when at least one bit of (source AND mask) was set at the previous clock edge.
- R3: A read at offset 0x000 returns ((i+1) << 2) in bits [15:0], where i is the lowest-numbered bit set in (source AND mask); line 0 has the highest priority.
- R4: A read at offset 0x000 returns 0 when no source bit is both set and enabled, including when lines are high but masked off.
- R5: The mask register is at offset 0x002, bit n enables line n; a write stores wr_data[15:0], a read returns it, and `irq_out` reflects the new mask one clock after the write edge.
- R6: Only bus_addr[11:0] is decoded; bits [15:12] have no effect on which register is reached.
- R7: Reads at any other offset (for example 0x001, 0x003, 0x004) return 0, and writes there leave the mask unchanged.
- R8: Synchronous active-high reset sets the mask to 0x0010, clears the source register and the synchroniser, and drives `irq_out` low.
- R9: Read data is registered: `rd_data` carries the result in the cycle after `rd_en` is sampled and is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 16 | Level-sensitive interrupt lines, asynchronous to clk |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte address; low 12 bits decoded |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq_out | output | 1 | Combined interrupt request, registered |

## Verification
A wrong mask bit shows at the ports on the next read of offset 0x002 and, when the matching line is high, as a wrong `irq_out` level one cycle later. A fault in the priority chain shows as a vector naming a higher-numbered line whenever two or more enabled lines are high at once, so the stimulus drives several overlapping line patterns with line 0, a middle line and line 15 as winners. A source register that lags or leads its input by a cycle is caught by sampling `irq_out` in the cycle before and the cycle of the expected rise.

// File: rtl/lbirq_pkg.sv
package lbirq_pkg;

  // Register selected by an access
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_MASK = 2'd2
  } lbirq_sel_e;

  localparam int DEC_W = 12;
  localparam logic [DEC_W-1:0] OFS_VEC  = 12'h000;
  localparam logic [DEC_W-1:0] OFS_MASK = 12'h002;

endpackage

// File: rtl/lbirq_sync.sv
module lbirq_sync #(
  parameter int NUM_LINES = 16,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_in,
  output logic [NUM_LINES-1:0] src_q
);

  logic [NUM_LINES-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= lines_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  // Source register: follows the synchronised level
  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= chain[STAGES-1];
  end

endmodule

// File: rtl/lbirq_prio_enc.sv
module lbirq_prio_enc #(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 16
) (
  input  logic [NUM_LINES-1:0] pend,
  output logic [NUM_LINES-1:0] first_oh,
  output logic [DATA_W-1:0]    vec_code
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES:0] seen;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  idx_ext;

  assign seen[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_chain
      assign seen[i+1]   = seen[i] | pend[i];
      assign first_oh[i] = pend[i] & ~seen[i];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (first_oh[k]) idx = idx | IDX_W'(k);
    end
  end

  assign idx_ext  = DATA_W'(idx);
  assign vec_code = seen[NUM_LINES] ? ((idx_ext + DATA_W'(1)) << 2) : '0;

endmodule

// File: rtl/lbirq_regs.sv
module lbirq_regs
  import lbirq_pkg::*;
#(
  parameter int                NUM_LINES = 16,
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 16,
  parameter logic [DATA_W-1:0] MASK_RST  = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [DATA_W-1:0]    vec_code,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [DATA_W-1:0]    rd_data
);

  logic [DEC_W-1:0] ofs;
  lbirq_sel_e       sel;

  assign ofs = bus_addr[DEC_W-1:0];

  always_comb begin
    if (ofs == OFS_VEC)       sel = SEL_VEC;
    else if (ofs == OFS_MASK) sel = SEL_MASK;
    else                      sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                             mask_q <= MASK_RST[NUM_LINES-1:0];
    else if (wr_en && sel == SEL_MASK)   mask_q <= wr_data[NUM_LINES-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      rd_data <= '0;
    end else begin
      case (sel)
        SEL_VEC:  rd_data <= vec_code;
        SEL_MASK: rd_data <= DATA_W'(mask_q);
        default:  rd_data <= '0;
      endcase
    end
  end

  // R5: a mask write lands one edge later
  a_r5_mask_written: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_MASK) |=> (mask_q == $past(wr_data[NUM_LINES-1:0])));

  // R7: unmapped write leaves mask alone
  a_r7_undef_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_NONE) |=> $stable(mask_q));

  // R7: unmapped read returns zero
  a_r7_undef_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> (rd_data == '0));

  // R3: vector codes are word aligned
  a_r3_vec_aligned: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_VEC) |=> (rd_data[1:0] == 2'b00));

  // R9: no read, no data
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

endmodule

// File: rtl/lbirq_prio_ctrl.sv
module lbirq_prio_ctrl #(
  parameter int                NUM_LINES   = 16,
  parameter int                DATA_W      = 16,
  parameter int                ADDR_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] MASK_RST    = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq_out
);

  localparam int LAT   = SYNC_STAGES + 1;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [NUM_LINES-1:0] src_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] first_oh;
  logic [DATA_W-1:0]    vec_code;

  lbirq_sync #(
    .NUM_LINES (NUM_LINES),
    .STAGES    (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .lines_in (irq_lines),
    .src_q    (src_q)
  );

  assign pend = src_q & mask_q;

  lbirq_prio_enc #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W)
  ) u_enc (
    .pend     (pend),
    .first_oh (first_oh),
    .vec_code (vec_code)
  );

  lbirq_regs #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MASK_RST  (MASK_RST)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .bus_addr (bus_addr),
    .wr_data  (wr_data),
    .vec_code (vec_code),
    .mask_q   (mask_q),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |pend;
  end

  // Cycles since reset, saturating, for the latency check
  logic [CNT_W-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                     since_rst <= '0;
    else if (since_rst != LAT[CNT_W-1:0]) since_rst <= since_rst + 1'b1;
  end

  // R1: source register equals the line levels LAT edges ago
  a_r1_src_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == LAT[CNT_W-1:0]) |-> (src_q == $past(irq_lines, LAT)));

  // R2: all lines masked off keeps the request low
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_out);

  // R2: any enabled pending line raises the request
  a_r2_pending_raises: assert property (@(posedge clk) disable iff (rst)
    (|(src_q & mask_q)) |=> irq_out);

  // R3: at most one winner from the priority chain
  a_r3_single_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(first_oh));

  // R8: reset state
  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (!irq_out && mask_q == MASK_RST[NUM_LINES-1:0] && src_q == '0));

endmodule

// File: tb/lbirq_prio_ctrl_test.sv
`timescale 1ns/1ps
module lbirq_prio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_lines = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic  [15:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  lbirq_prio_ctrl uut (
    .clk       (clk),
    .rst       (rst),
    .irq_lines (irq_lines),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .bus_addr  (bus_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .irq_out   (irq_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Driver: issue a read and push the expected data
  task automatic do_read(input logic [15:0] addr, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_addr = addr;
    rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] addr, input logic [15:0] data);
    @(negedge clk);
    bus_addr = addr;
    wr_data = data;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk);
    irq_lines = v;
    repeat (5) @(negedge clk);
  endtask

  // Monitor: compare each read result in the following cycle
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8: reset state
    check("R8 irq_out after reset", {15'd0, irq_out}, 16'h0000);
    do_read(16'h0002, 16'h0010, "R8 mask reset value");
    do_read(16'h0000, 16'h0000, "R8 R4 vector empty after reset");

    // R9: idle cycle gives zero data
    @(negedge clk);
    check("R9 idle rd_data", rd_data, 16'h0000);

    // R2 R3: line 4 is enabled by the reset mask
    set_lines(16'h0010);
    check("R2 irq_out with line 4", {15'd0, irq_out}, 16'h0001);
    do_read(16'h0000, 16'd20, "R3 vector line 4");

    // R3: priority among several lines
    do_write(16'h0002, 16'hFFFF);
    set_lines(16'h0210);
    do_read(16'h0000, 16'd20, "R3 lines 4 and 9 -> 4");
    set_lines(16'h0200);
    do_read(16'h0000, 16'd40, "R3 line 9");
    set_lines(16'h8000);
    do_read(16'h0000, 16'd64, "R3 line 15");
    set_lines(16'hFFFF);
    do_read(16'h0000, 16'd4, "R3 all lines -> line 0");

    // R5: mask write takes effect one cycle after the write edge
    @(negedge clk);
    bus_addr = 16'h0002; wr_data = 16'h0000; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R5 irq_out the cycle of the write edge", {15'd0, irq_out}, 16'h0001);
    @(negedge clk);
    check("R5 irq_out one cycle after mask write", {15'd0, irq_out}, 16'h0000);
    do_read(16'h0002, 16'h0000, "R5 mask readback");
    do_read(16'h0000, 16'h0000, "R4 lines high but masked");

    // R5: selective mask
    do_write(16'h0002, 16'h0100);
    do_read(16'h0000, 16'd36, "R5 R3 only line 8 enabled");

    // R1: synchroniser latency
    set_lines(16'h0000);
    do_write(16'h0002, 16'h0008);
    @(negedge clk);
    irq_lines = 16'h0008;
    repeat (3) @(negedge clk);
    check("R1 irq_out before latency", {15'd0, irq_out}, 16'h0000);
    @(negedge clk);
    check("R1 irq_out at latency", {15'd0, irq_out}, 16'h0001);
    @(negedge clk);
    irq_lines = 16'h0000;
    repeat (4) @(negedge clk);
    check("R1 irq_out after line drops", {15'd0, irq_out}, 16'h0000);

    // R6: upper address bits ignored
    do_write(16'h5002, 16'h00F0);
    do_read(16'hA002, 16'h00F0, "R6 aliased mask access");
    set_lines(16'h0040);
    do_read(16'hF000, 16'd28, "R6 aliased vector access");

    // R7: unmapped offsets
    do_write(16'h0004, 16'hFFFF);
    do_write(16'h0003, 16'hFFFF);
    do_read(16'h0002, 16'h00F0, "R7 mask unchanged by unmapped write");
    do_read(16'h0004, 16'h0000, "R7 read 0x004");
    do_read(16'h0003, 16'h0000, "R7 read 0x003");
    do_read(16'h0001, 16'h0000, "R7 read 0x001");

    // R8: reset again restores mask and clears output
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    irq_lines = 16'h0000;
    check("R8 irq_out after second reset", {15'd0, irq_out}, 16'h0000);
    do_read(16'h0002, 16'h0010, "R8 mask after second reset");

    repeat (3) @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule